// File: doc/BRIEF.md
# Leaky integrate-and-fire neuron

This block is a single synchronous spiking neuron that runs in discrete timesteps. During a configuration phase it stores five signed integers: a leak, a firing threshold and one weight for each of three axon types. In the run phase a strobe delivers synaptic events, each tagged with a 2-bit axon type. The neuron sums the matching weights into an accumulator. A timestep tick folds that sum into the membrane and subtracts the leak. It then fires a one-cycle spike if the result is strictly above the threshold, and resets or clips the membrane.

Every result is a plain integer, so a software model of the same rules matches it bit for bit. The accumulator and the membrane use wider saturating arithmetic, so a burst of events cannot wrap around.

Control is a two-state machine. S_CFG accepts parameter writes and holds the membrane and accumulator at zero. S_RUN integrates events and processes ticks. Transition T_START (S_CFG to S_RUN) is taken when `cfg_en` is low at a clock edge. Transition T_RECONF (S_RUN to S_CFG) is taken when `cfg_en` is high. Otherwise each state holds.

Top module: `lif_neuron`

## Requirements
- R1: After reset the machine is in S_CFG, `membrane_o` is 0, `spike_o` is 0, and all five parameters are 0.
- R2: A parameter is written only at an edge where both `cfg_en` and `cfg_we` are high. `cfg_sel` picks the target: 0 leak, 1 threshold, 2 weight of type 0, 3 weight of type 1, 4 weight of type 2. Other select codes are ignored, and so is `cfg_we` while `cfg_en` is low.
- R3: In S_RUN with `cfg_en` low, an event of type 0, 1 or 2 adds the matching signed weight to the accumulator. An event of type 3 is ignored.
- R4: At a tick in S_RUN with `cfg_en` low, the candidate is membrane + accumulator − leak. The candidate becomes the new membrane unless R5 or R6 applies. It is visible on `membrane_o` after that edge.
- R5: If the candidate is strictly greater than the threshold, `spike_o` is high for the one cycle after the tick edge and the membrane becomes 0. A candidate equal to the threshold does not fire.
- R6: A candidate below 0 that does not fire sets the membrane to 0, so `membrane_o` is never negative.
- R7: The accumulator is cleared at each tick. An event in the tick cycle counts toward the following timestep.
- R8: Both additions in the accumulator and both steps of the membrane update saturate at the signed limits of the DW-bit width instead of wrapping.
- R9: In S_CFG, and in any cycle where `cfg_en` is high, events and ticks have no effect. While in S_CFG the membrane and accumulator are held at 0 and no spike is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration phase enable |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 3 | Parameter select |
| cfg_data | input | PW | Signed parameter value |
| ev_valid | input | 1 | Synaptic event strobe |
| ev_type | input | 2 | Axon type of the event |
| tick | input | 1 | Timestep tick |
| spike_o | output | 1 | One-cycle spike flag |
| membrane_o | output | DW | Current signed membrane value |

## Verification
The assertions check on every cycle that:
- the membrane is never negative;
- a spike leaves the membrane at zero and follows a tick in the run phase;
- a type-3 event leaves the accumulator unchanged;
- a tick without an event empties it;
- S_CFG forces a zero membrane and no spike;
- parameters do not move while `cfg_en` is low.

Only the bench scenarios can show that the arithmetic is right: the strict threshold at equality, the leak applied once per tick, a same-cycle event deferred to the next timestep, and negative saturation of a long burst preventing a false spike.

// File: rtl/lif_pkg.sv
package lif_pkg;

    typedef enum logic [0:0] {
        S_CFG = 1'b0,
        S_RUN = 1'b1
    } lif_state_e;

    typedef enum logic [2:0] {
        SEL_LEAK = 3'd0,
        SEL_THR  = 3'd1,
        SEL_W0   = 3'd2,
        SEL_W1   = 3'd3,
        SEL_W2   = 3'd4
    } lif_sel_e;

    localparam int NTYPES   = 3;
    localparam int TYPE_BAD = 3;

endpackage

// File: rtl/lif_sat_add.sv
module lif_sat_add #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {a[W-1], a} + {b[W-1], b};
        if (wide[W] != wide[W-1]) begin
            y = wide[W] ? MINV : MAXV;
        end else begin
            y = wide[W-1:0];
        end
    end
endmodule

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs
    import lif_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             sel,
    input  logic [PW-1:0]          data,
    output logic [PW-1:0]          leak,
    output logic [PW-1:0]          thr,
    output logic [NTYPES*PW-1:0]   wt_flat
);
    logic [PW-1:0] leak_q, thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leak_q <= '0;
            thr_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_LEAK) leak_q <= data;
            if (sel == SEL_THR)  thr_q  <= data;
        end
    end

    for (genvar g = 0; g < NTYPES; g++) begin : g_wt
        logic [PW-1:0] w_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else if (wr_en && (sel == 3'(int'(SEL_W0) + g))) begin
                w_q <= data;
            end
        end
        assign wt_flat[g*PW +: PW] = w_q;
    end

    assign leak = leak_q;
    assign thr  = thr_q;
endmodule

// File: rtl/lif_accum.sv
module lif_accum
    import lif_pkg::*;
#(
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   run,
    input  logic                   tick,
    input  logic                   ev_valid,
    input  logic [1:0]             ev_type,
    input  logic [NTYPES*PW-1:0]   wt_flat,
    output logic signed [DW-1:0]   acc
);
    logic [PW-1:0]        wt [NTYPES];
    logic [PW-1:0]        w_sel;
    logic                 add_en;
    logic signed [DW-1:0] addend, base, acc_n, acc_q;

    for (genvar g = 0; g < NTYPES; g++) begin : g_unpack
        assign wt[g] = wt_flat[g*PW +: PW];
    end

    always_comb begin
        w_sel = '0;
        case (ev_type)
            2'd0:    w_sel = wt[0];
            2'd1:    w_sel = wt[1];
            2'd2:    w_sel = wt[2];
            default: w_sel = '0;
        endcase
    end

    assign add_en = ev_valid && (ev_type != 2'(TYPE_BAD));
    assign addend = add_en ? {{(DW-PW){w_sel[PW-1]}}, w_sel} : '0;
    assign base   = tick ? '0 : acc_q;

    lif_sat_add #(.W(DW)) u_add (.a(base), .b(addend), .y(acc_n));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (run) acc_q <= acc_n;
    end

    assign acc = acc_q;

    // R3: an illegal type leaves the sum alone
    a_r3_bad_type_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && ev_valid && ev_type == 2'd3 && !tick) |=> $stable(acc_q));

    // R7: a tick with no event empties the accumulator
    a_r7_tick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && tick && !ev_valid) |=> (acc_q == '0));
endmodule

// File: rtl/lif_membrane.sv
module lif_membrane #(
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   run,
    input  logic                   tick,
    input  logic signed [DW-1:0]   acc,
    input  logic [PW-1:0]          leak,
    input  logic [PW-1:0]          thr,
    output logic signed [DW-1:0]   v,
    output logic                   spike
);
    logic signed [DW-1:0] v_q, sum1, cand, neg_leak, thr_ext;
    logic                 spike_q, fire;

    assign neg_leak = -{{(DW-PW){leak[PW-1]}}, leak};
    assign thr_ext  = {{(DW-PW){thr[PW-1]}}, thr};

    lif_sat_add #(.W(DW)) u_integ (.a(v_q),  .b(acc),      .y(sum1));
    lif_sat_add #(.W(DW)) u_leak  (.a(sum1), .b(neg_leak), .y(cand));

    assign fire = (cand > thr_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q     <= '0;
            spike_q <= 1'b0;
        end else if (clr) begin
            v_q     <= '0;
            spike_q <= 1'b0;
        end else if (run && tick) begin
            spike_q <= fire;
            if (fire || cand < 0) v_q <= '0;
            else                  v_q <= cand;
        end else begin
            spike_q <= 1'b0;
        end
    end

    assign v     = v_q;
    assign spike = spike_q;

    // R6: the membrane is never negative
    a_r6_nonnegative: assert property (@(posedge clk) disable iff (!rst_n)
        !v_q[DW-1]);

    // R5: firing leaves the membrane at zero
    a_r5_reset_on_spike: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> (v_q == '0));

    // R5: a spike only follows a processed tick
    a_r5_spike_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> $past(run && tick && !clr));
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
    import lif_pkg::*;
#(
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [PW-1:0] cfg_data,
    input  logic          ev_valid,
    input  logic [1:0]    ev_type,
    input  logic          tick,
    output logic          spike_o,
    output logic [DW-1:0] membrane_o
);
    lif_state_e state_q, state_n;
    logic       clr, run;

    logic [PW-1:0]        leak_w, thr_w;
    logic [NTYPES*PW-1:0] wt_w;
    logic signed [DW-1:0] acc_w, v_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CFG;
        else        state_q <= state_n;
    end

    // next state: T_START leaves S_CFG, T_RECONF returns to it
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_CFG: if (!cfg_en) state_n = S_RUN;
            S_RUN: if (cfg_en)  state_n = S_CFG;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        clr = 1'b0;
        run = 1'b0;
        unique case (state_q)
            S_CFG: clr = 1'b1;
            S_RUN: run = !cfg_en;
        endcase
    end

    lif_cfg_regs #(.PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_en && cfg_we),
        .sel(cfg_sel), .data(cfg_data),
        .leak(leak_w), .thr(thr_w), .wt_flat(wt_w)
    );

    lif_accum #(.PW(PW), .DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .tick(tick),
        .ev_valid(ev_valid), .ev_type(ev_type), .wt_flat(wt_w), .acc(acc_w)
    );

    lif_membrane #(.PW(PW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .tick(tick),
        .acc(acc_w), .leak(leak_w), .thr(thr_w), .v(v_w), .spike(spike_o)
    );

    assign membrane_o = v_w;

    // R9: configuration state keeps the neuron quiet
    a_r9_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CFG) |=> (membrane_o == '0 && !spike_o));

    // R2: parameters move only with cfg_en high
    a_r2_cfg_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(leak_w) && $stable(thr_w) && $stable(wt_w)));
endmodule

// File: tb/sim_lif_neuron.sv
module sim_lif_neuron;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b1, cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [PW-1:0] cfg_data = '0;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_type = '0;
    logic          tick = 1'b0;
    logic          spike_o;
    logic [DW-1:0] membrane_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lif_neuron #(.PW(PW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ev_valid(ev_valid),
        .ev_type(ev_type), .tick(tick), .spike_o(spike_o), .membrane_o(membrane_o)
    );

    // behavioural reference
    int  m_v, m_acc, m_leak, m_thr;
    int  m_w [3];
    bit  m_spk, m_cfg;

    function automatic int sat(int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int sx(logic [PW-1:0] d);
        return int'($signed(d));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_v = 0; m_acc = 0; m_spk = 0; m_cfg = 1;
            m_leak = 0; m_thr = 0; m_w[0] = 0; m_w[1] = 0; m_w[2] = 0;
        end else begin
            m_spk = 0;
            if (m_cfg) begin
                m_v = 0; m_acc = 0;
            end else if (!cfg_en) begin
                if (tick) begin
                    int t;
                    t = sat(sat(m_v + m_acc) - m_leak);
                    if (t > m_thr) begin m_v = 0; m_spk = 1; end
                    else if (t < 0) m_v = 0;
                    else m_v = t;
                    m_acc = 0;
                end
                if (ev_valid && ev_type != 2'd3) m_acc = sat(m_acc + m_w[ev_type]);
            end
            if (cfg_en && cfg_we) begin
                case (cfg_sel)
                    3'd0: m_leak = sx(cfg_data);
                    3'd1: m_thr  = sx(cfg_data);
                    3'd2: m_w[0] = sx(cfg_data);
                    3'd3: m_w[1] = sx(cfg_data);
                    3'd4: m_w[2] = sx(cfg_data);
                    default: ;
                endcase
            end
            m_cfg = cfg_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference (R4, R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'($signed(membrane_o)) == m_v, "R4 membrane vs model",
                int'($signed(membrane_o)), m_v);
            chk(spike_o == m_spk, "R5 spike vs model", int'(spike_o), int'(m_spk));
        end
    end

    task automatic cyc(input logic e, input logic [1:0] t, input logic k);
        ev_valid = e; ev_type = t; tick = k;
        @(negedge clk);
        ev_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [PW-1:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int mem();
        return int'($signed(membrane_o));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem() == 0 && spike_o == 0, "R1 reset state", mem(), 0);

        // configuration: leak 3, threshold 20, weights 10, 3, -8
        wr(3'd0, 8'd3);
        wr(3'd1, 8'd20);
        wr(3'd2, 8'd10);
        wr(3'd3, 8'd3);
        wr(3'd4, 8'hF8);
        wr(3'd7, 8'd99);
        cyc(1'b1, 2'd0, 1'b1);
        chk(mem() == 0 && spike_o == 0, "R9 events ignored in config", mem(), 0);
        cfg_en = 1'b0;
        @(negedge clk);

        // 10 + 10 + 3 - 3 = 20, equal to threshold: no spike
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b1, 2'd1, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 20 && spike_o == 0, "R5 equal does not fire", mem(), 20);

        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 17, "R4 leak on empty tick", mem(), 17);

        cyc(1'b1, 2'd3, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 14, "R3 type 3 ignored", mem(), 14);

        cyc(1'b1, 2'd0, 1'b1);
        chk(mem() == 11, "R7 same-cycle event deferred", mem(), 11);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 18, "R7 deferred event applied", mem(), 18);

        // write attempt with cfg_en low must not change the leak
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 8'd50;
        @(negedge clk);
        cfg_we = 1'b0;
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 15, "R2 write blocked while cfg_en low", mem(), 15);

        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(spike_o == 1 && mem() == 0, "R5 spike and reset", int'(spike_o), 1);
        @(negedge clk);
        chk(spike_o == 0, "R5 spike lasts one cycle", int'(spike_o), 0);

        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 7, "R4 integrate", mem(), 7);
        cyc(1'b1, 2'd2, 1'b0);
        cyc(1'b1, 2'd2, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 0 && spike_o == 0, "R6 negative clipped", mem(), 0);

        // saturation: long inhibitory burst must not wrap positive
        cfg_en = 1'b1;
        @(negedge clk);
        wr(3'd4, 8'h80);
        wr(3'd2, 8'd127);
        cfg_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'd2, 1'b0);
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(mem() == 0 && spike_o == 0, "R8 negative saturation", int'(spike_o), 0);

        // positive burst saturates and fires
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        chk(spike_o == 1, "R8 positive saturation fires", int'(spike_o), 1);

        // back to config: membrane held at zero, ticks ignored (R9)
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b0, 2'd0, 1'b1);
        cfg_en = 1'b1;
        cyc(1'b1, 2'd0, 1'b1);
        cyc(1'b1, 2'd0, 1'b1);
        chk(mem() == 0 && spike_o == 0, "R9 reconfig clears membrane", mem(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule